// File: doc/BRIEF.md
# Receive Phase Alignment Sequencer

This block is a fabric-side controller for one serial receive lane that runs with its elastic buffer bypassed. It waits until the lane has left electrical idle and clock-data recovery reports lock. It then issues a short delay-reset request to the transceiver. Next it follows the transceiver's handshake in a fixed order: delay-reset done, then sync done. When sync done arrives it samples phase-align done to decide whether the lane is aligned. The outcome is a steady aligned flag or a one-cycle failure flag.

The sequencer starts the procedure again on its own in several cases: a receiver reset, a receive rate change, a loss of lock, a return to electrical idle, a handshake timeout, a failed phase result, or a report of bad received data from downstream logic. A saturating retry count records the automatic re-runs. The lock, idle and handshake inputs are asynchronous to the controller clock, so each passes through a two-flop synchronizer. The block also drives the lane's sync configuration for single-lane automatic operation.

States: IDLE (reset or receiver reset held), WAIT_LOCK (waiting for lock and no idle), PULSE (start request high), WAIT_RSTDONE (waiting for delay-reset done), WAIT_SYNC (waiting for a fresh sync done), ALIGNED (success) and FAIL (one-cycle failure). Transitions:
- IDLE goes to WAIT_LOCK once the receiver reset is released.
- WAIT_LOCK goes to PULSE when the lane is up.
- PULSE goes to WAIT_RSTDONE after the configured width.
- WAIT_RSTDONE goes to WAIT_SYNC on delay-reset done, or to WAIT_LOCK on timeout.
- WAIT_SYNC goes to ALIGNED or FAIL on sync done, or to WAIT_LOCK on timeout.
- ALIGNED goes to WAIT_LOCK on bad data.
- FAIL goes to WAIT_LOCK.
- Any state goes to IDLE on receiver reset.
- Any state after WAIT_LOCK goes to WAIT_LOCK on loss of lock, on idle, or on a rate change.

Top module: `rx_phase_align_seq`

## Requirements
- R1: The start request (`dly_rst_o`) rises only while the synchronized lock is high and the synchronized idle is low. While either condition is missing it stays low.
- R2: Each start request stays high for exactly PULSE_CYCLES clock cycles. Elaboration stops with an error unless PULSE_CYCLES times CLK_PERIOD_PS is below 50000 ps.
- R3: After the request ends, the sequencer waits for delay-reset done as a level. Only then does it accept sync done, and only a sync done that was seen low after the request began.
- R4: When sync done arrives with phase-align done high, `aligned_o` goes high and stays high. If phase-align done is low, `failed_o` is high for exactly one cycle, the retry count rises by one, and a new request follows.
- R5: If delay-reset done does not arrive within RSTDONE_TMO cycles, or sync done within SYNC_TMO cycles, the sequencer restarts from WAIT_LOCK and the retry count rises by one.
- R6: `data_bad_i` high while aligned clears `aligned_o` at the next clock edge, raises the retry count by one, and starts a new request.
- R7: `rx_reset_i` high forces IDLE at the next edge. Request, busy and aligned are then low until it is released. It does not clear the retry count.
- R8: `rate_change_i` high in any state after IDLE restarts from WAIT_LOCK without raising the retry count. It takes priority over `data_bad_i` in the same cycle.
- R9: Loss of lock or re-entry into electrical idle in any state after WAIT_LOCK returns to WAIT_LOCK without raising the retry count. `aligned_o` falls three edges after the raw input changes.
- R10: The retry count saturates at its all-ones value, never decreases except at reset, and rises by at most one per cycle.
- R11: `sync_mode_o` is constantly high, and `sync_all_o` follows `sync_out_i` combinationally.
- R12: During reset all flags and the retry count are zero. `busy_o` is high exactly in WAIT_LOCK, PULSE, WAIT_RSTDONE and WAIT_SYNC. At most one of `busy_o`, `aligned_o` and `failed_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_reset_i | input | 1 | Receiver reset in progress (synchronous) |
| rate_change_i | input | 1 | Receive rate change strobe (synchronous) |
| cdr_lock_i | input | 1 | Clock-data recovery lock (asynchronous) |
| elec_idle_i | input | 1 | Lane in electrical idle (asynchronous) |
| dly_rst_done_i | input | 1 | Delay-reset done from transceiver (asynchronous) |
| sync_done_i | input | 1 | Alignment sync done from transceiver (asynchronous) |
| phase_done_i | input | 1 | Phase-align done from transceiver (asynchronous) |
| sync_out_i | input | 1 | Lane's own sync output |
| data_bad_i | input | 1 | Downstream invalid-data report (synchronous) |
| dly_rst_o | output | 1 | Delay-reset start request |
| sync_mode_o | output | 1 | Sync mode configuration, held high |
| sync_all_o | output | 1 | Sync-all input, looped from sync_out_i |
| busy_o | output | 1 | Procedure in progress |
| aligned_o | output | 1 | Lane aligned |
| failed_o | output | 1 | One-cycle alignment failure flag |
| retry_cnt_o | output | RETRY_W | Saturating count of automatic re-runs |

## Verification
Bad received data and a rate change can both restart an aligned lane, but only bad data adds to the retry count. The bench drives `data_bad_i` and `rate_change_i` in the same cycle while the lane is aligned. It expects `aligned_o` to drop at the next edge and the following request and alignment to report an unchanged retry count. A scoreboard of expected request, alignment and failure events, each tagged with its expected retry value, judges every restart path in order. A transceiver model in the bench answers each request with delay-reset done and sync done, and it can withhold either one.

// File: rtl/rxpa_pkg.sv
`timescale 1ns/1ps
package rxpa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE         = 3'd0,
        ST_WAIT_LOCK    = 3'd1,
        ST_PULSE        = 3'd2,
        ST_WAIT_RSTDONE = 3'd3,
        ST_WAIT_SYNC    = 3'd4,
        ST_ALIGNED      = 3'd5,
        ST_FAIL         = 3'd6
    } rxpa_state_e;

    // bit positions inside the synchronized input vector
    localparam int SY_LOCK  = 0;
    localparam int SY_IDLE  = 1;
    localparam int SY_RDONE = 2;
    localparam int SY_SDONE = 3;
    localparam int SY_PHASE = 4;
    localparam int SY_COUNT = 5;

    // upper bound on the start request width
    localparam longint START_LIMIT_PS = 64'd50000;

    function automatic int rxpa_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rxpa_sync.sv
`timescale 1ns/1ps
module rxpa_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic stage1;
        logic stage2;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1 <= RST_VAL[i];
                stage2 <= RST_VAL[i];
            end else begin
                stage1 <= d[i];
                stage2 <= stage1;
            end
        end

        assign q[i] = stage2;
    end

endmodule

// File: rtl/rxpa_dwell.sv
`timescale 1ns/1ps
module rxpa_dwell #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (count != {W{1'b1}}) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/rxpa_retry.sv
`timescale 1ns/1ps
module rxpa_retry #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (bump && (count != {W{1'b1}})) begin
            count <= count + 1'b1;
        end
    end

    AST_RETRY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (count == $past(count)) || (count == $past(count) + 1'b1)); // R10

endmodule

// File: rtl/rx_phase_align_seq.sv
`timescale 1ns/1ps
module rx_phase_align_seq
    import rxpa_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int PULSE_CYCLES  = 8,
    parameter int RSTDONE_TMO   = 1024,
    parameter int SYNC_TMO      = 4096,
    parameter int RETRY_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_reset_i,
    input  logic               rate_change_i,
    input  logic               cdr_lock_i,
    input  logic               elec_idle_i,
    input  logic               dly_rst_done_i,
    input  logic               sync_done_i,
    input  logic               phase_done_i,
    input  logic               sync_out_i,
    input  logic               data_bad_i,
    output logic               dly_rst_o,
    output logic               sync_mode_o,
    output logic               sync_all_o,
    output logic               busy_o,
    output logic               aligned_o,
    output logic               failed_o,
    output logic [RETRY_W-1:0] retry_cnt_o
);

    localparam int     MAX_SPAN   = rxpa_max3(PULSE_CYCLES, RSTDONE_TMO, SYNC_TMO);
    localparam int     DWELL_W    = $clog2(MAX_SPAN + 1);
    localparam longint START_PS   = longint'(PULSE_CYCLES) * longint'(CLK_PERIOD_PS);
    localparam logic [DWELL_W-1:0] PULSE_LAST = DWELL_W'(PULSE_CYCLES - 1);
    localparam logic [DWELL_W-1:0] RDONE_LAST = DWELL_W'(RSTDONE_TMO - 1);
    localparam logic [DWELL_W-1:0] SYNC_LAST  = DWELL_W'(SYNC_TMO - 1);
    localparam logic [SY_COUNT-1:0] SY_RST    = SY_COUNT'(1) << SY_IDLE;

    // elaboration checks on the timing parameters
    if (START_PS >= START_LIMIT_PS) begin : g_start_too_wide
        $error("start request of %0d cycles at %0d ps is not below 50 ns",
               PULSE_CYCLES, CLK_PERIOD_PS);
    end
    if (PULSE_CYCLES < 1) begin : g_start_empty
        $error("PULSE_CYCLES must be at least 1");
    end
    if (RSTDONE_TMO < 2 || SYNC_TMO < 2) begin : g_tmo_short
        $error("timeouts must be at least 2 cycles");
    end

    // ------------------------------------------------------------------
    // input synchronizers
    // ------------------------------------------------------------------
    logic [SY_COUNT-1:0] raw_in;
    logic [SY_COUNT-1:0] syn_in;

    assign raw_in[SY_LOCK]  = cdr_lock_i;
    assign raw_in[SY_IDLE]  = elec_idle_i;
    assign raw_in[SY_RDONE] = dly_rst_done_i;
    assign raw_in[SY_SDONE] = sync_done_i;
    assign raw_in[SY_PHASE] = phase_done_i;

    rxpa_sync #(
        .W       (SY_COUNT),
        .RST_VAL (SY_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    logic lock_s;
    logic idle_s;
    logic rdone_s;
    logic sdone_s;
    logic phase_s;
    logic link_up;

    assign lock_s  = syn_in[SY_LOCK];
    assign idle_s  = syn_in[SY_IDLE];
    assign rdone_s = syn_in[SY_RDONE];
    assign sdone_s = syn_in[SY_SDONE];
    assign phase_s = syn_in[SY_PHASE];
    assign link_up = lock_s && !idle_s;

    // single-lane automatic configuration
    assign sync_mode_o = 1'b1;
    assign sync_all_o  = sync_out_i;

    // ------------------------------------------------------------------
    // state, dwell counter and retry counter
    // ------------------------------------------------------------------
    rxpa_state_e        state;
    rxpa_state_e        state_nx;
    logic               bump;
    logic               restart;
    logic               sdone_low_seen;
    logic [DWELL_W-1:0] dwell;
    logic               past_lock_wait;

    assign restart        = (state_nx != state);
    assign past_lock_wait = (state != ST_IDLE) && (state != ST_WAIT_LOCK);

    rxpa_dwell #(
        .W (DWELL_W)
    ) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .count   (dwell)
    );

    rxpa_retry #(
        .W (RETRY_W)
    ) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (bump),
        .count (retry_cnt_o)
    );

    // next state: restart causes first, in priority order, then the walk
    always_comb begin
        state_nx = state;
        bump     = 1'b0;
        if (rx_reset_i) begin
            state_nx = ST_IDLE;
        end else if (past_lock_wait && !link_up) begin
            state_nx = ST_WAIT_LOCK;
        end else if ((state != ST_IDLE) && rate_change_i) begin
            state_nx = ST_WAIT_LOCK;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_nx = ST_WAIT_LOCK;
                end
                ST_WAIT_LOCK: begin
                    if (link_up) begin
                        state_nx = ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    if (dwell == PULSE_LAST) begin
                        state_nx = ST_WAIT_RSTDONE;
                    end
                end
                ST_WAIT_RSTDONE: begin
                    if (rdone_s) begin
                        state_nx = ST_WAIT_SYNC;
                    end else if (dwell == RDONE_LAST) begin
                        state_nx = ST_WAIT_LOCK;
                        bump     = 1'b1;
                    end
                end
                ST_WAIT_SYNC: begin
                    if (sdone_s && sdone_low_seen) begin
                        state_nx = phase_s ? ST_ALIGNED : ST_FAIL;
                    end else if (dwell == SYNC_LAST) begin
                        state_nx = ST_WAIT_LOCK;
                        bump     = 1'b1;
                    end
                end
                ST_ALIGNED: begin
                    if (data_bad_i) begin
                        state_nx = ST_WAIT_LOCK;
                        bump     = 1'b1;
                    end
                end
                ST_FAIL: begin
                    state_nx = ST_WAIT_LOCK;
                    bump     = 1'b1;
                end
                default: begin
                    state_nx = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // a sync done counts only once it has been seen low in this run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdone_low_seen <= 1'b0;
        end else if ((state_nx == ST_PULSE) && (state != ST_PULSE)) begin
            sdone_low_seen <= 1'b0;
        end else if (!sdone_s) begin
            sdone_low_seen <= 1'b1;
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_rst_o <= 1'b0;
            busy_o    <= 1'b0;
            aligned_o <= 1'b0;
            failed_o  <= 1'b0;
        end else begin
            dly_rst_o <= (state_nx == ST_PULSE);
            busy_o    <= (state_nx == ST_WAIT_LOCK) || (state_nx == ST_PULSE) ||
                         (state_nx == ST_WAIT_RSTDONE) || (state_nx == ST_WAIT_SYNC);
            aligned_o <= (state_nx == ST_ALIGNED);
            failed_o  <= (state_nx == ST_FAIL);
        end
    end

    // ------------------------------------------------------------------
    // checks
    // ------------------------------------------------------------------
    logic [DWELL_W-1:0] start_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_run <= '0;
        end else if (!dly_rst_o) begin
            start_run <= '0;
        end else if (start_run != {DWELL_W{1'b1}}) begin
            start_run <= start_run + 1'b1;
        end
    end

    AST_START_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dly_rst_o) |-> ($past(lock_s) && !$past(idle_s))); // R1

    AST_START_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        dly_rst_o |-> (start_run < DWELL_W'(PULSE_CYCLES))); // R2

    AST_SYNC_AFTER_RDONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned_o) |-> $past(sdone_low_seen)); // R3

    AST_ALIGN_NEEDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned_o) |-> ($past(phase_s) && $past(sdone_s))); // R4

    AST_FAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        failed_o |=> !failed_o); // R4

    AST_BAD_DATA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned_o && data_bad_i) |=> !aligned_o); // R6

    AST_RX_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset_i |=> (!busy_o && !aligned_o && !dly_rst_o)); // R7

    AST_RATE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned_o && rate_change_i) |=> !aligned_o); // R8

    AST_LINK_LOSS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned_o && !link_up) |=> !aligned_o); // R9

    AST_RETRY_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (retry_cnt_o >= $past(retry_cnt_o))); // R10

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, aligned_o, failed_o})); // R12

endmodule

// File: tb/rx_phase_align_seq_test.sv
`timescale 1ns/1ps
module rx_phase_align_seq_test;

    localparam int PULSE_CYCLES = 8;
    localparam int RSTDONE_TMO  = 64;
    localparam int SYNC_TMO     = 64;
    localparam int RETRY_W      = 3;
    localparam int RETRY_MAX    = (1 << RETRY_W) - 1;

    // transceiver model timing, cycles after the request rises
    localparam int RDONE_AT  = 12;
    localparam int RDONE_LEN = 30;
    localparam int SDONE_AT  = 50;

    localparam int EV_PULSE = 1;
    localparam int EV_ALIGN = 2;
    localparam int EV_FAIL  = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               rx_reset_i = 1'b0;
    logic               rate_change_i = 1'b0;
    logic               cdr_lock_i = 1'b0;
    logic               elec_idle_i = 1'b1;
    logic               dly_rst_done_i = 1'b0;
    logic               sync_done_i = 1'b0;
    logic               phase_done_i = 1'b0;
    logic               sync_out_i = 1'b0;
    logic               data_bad_i = 1'b0;
    logic               dly_rst_o;
    logic               sync_mode_o;
    logic               sync_all_o;
    logic               busy_o;
    logic               aligned_o;
    logic               failed_o;
    logic [RETRY_W-1:0] retry_cnt_o;

    always #2 clk = ~clk;

    rx_phase_align_seq #(
        .CLK_PERIOD_PS (4000),
        .PULSE_CYCLES  (PULSE_CYCLES),
        .RSTDONE_TMO   (RSTDONE_TMO),
        .SYNC_TMO      (SYNC_TMO),
        .RETRY_W       (RETRY_W)
    ) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_reset_i     (rx_reset_i),
        .rate_change_i  (rate_change_i),
        .cdr_lock_i     (cdr_lock_i),
        .elec_idle_i    (elec_idle_i),
        .dly_rst_done_i (dly_rst_done_i),
        .sync_done_i    (sync_done_i),
        .phase_done_i   (phase_done_i),
        .sync_out_i     (sync_out_i),
        .data_bad_i     (data_bad_i),
        .dly_rst_o      (dly_rst_o),
        .sync_mode_o    (sync_mode_o),
        .sync_all_o     (sync_all_o),
        .busy_o         (busy_o),
        .aligned_o      (aligned_o),
        .failed_o       (failed_o),
        .retry_cnt_o    (retry_cnt_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int    kind;
        int    retry;
        string tag;
    } ev_t;

    ev_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic expect_ev(input int kind, input int retry, input string tag);
        ev_t e;
        e.kind  = kind;
        e.retry = retry;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // ---------------- transceiver model ----------------
    bit resp_rdone = 1'b1;
    bit resp_sdone = 1'b1;
    bit phase_ok   = 1'b1;
    int model_t    = 1000;
    bit model_prev = 1'b0;

    initial begin : xcvr_model
        forever begin
            @(negedge clk);
            if (dly_rst_o && !model_prev) begin
                model_t     = 0;
                sync_done_i = 1'b0;
            end else if (model_t < 1000) begin
                model_t++;
            end
            model_prev     = dly_rst_o;
            dly_rst_done_i = resp_rdone && (model_t >= RDONE_AT) &&
                             (model_t < RDONE_AT + RDONE_LEN);
            if (resp_sdone && (model_t == SDONE_AT)) begin
                sync_done_i  = 1'b1;
                phase_done_i = phase_ok;
            end
        end
    end

    // ---------------- monitor / scoreboard ----------------
    bit p_dly = 1'b0;
    bit p_al  = 1'b0;
    bit p_fl  = 1'b0;
    int run   = 0;

    task automatic take(input int kind);
        ev_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "scoreboard unexpected event", kind, 0);
        end else begin
            e = exp_q.pop_front();
            chk((e.kind == kind) && (e.retry == int'(retry_cnt_o)), e.tag,
                kind * 100 + int'(retry_cnt_o), e.kind * 100 + e.retry);
        end
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (dly_rst_o && !p_dly) take(EV_PULSE);
                if (aligned_o && !p_al)  take(EV_ALIGN);
                if (failed_o && !p_fl)   take(EV_FAIL);
                if (dly_rst_o) begin
                    run++;
                end else if (p_dly) begin
                    chk(run == PULSE_CYCLES, "R2 start width", run, PULSE_CYCLES);
                    run = 0;
                end
            end
            p_dly = dly_rst_o;
            p_al  = aligned_o;
            p_fl  = failed_o;
        end
    end

    // ---------------- helpers ----------------
    task automatic wait_aligned(input string tag);
        for (int i = 0; i < 2000 && !aligned_o; i++) @(negedge clk);
        chk(aligned_o, tag, aligned_o, 1);
    endtask

    task automatic wait_drained(input string tag);
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic pulse_input(input int which);
        @(negedge clk);
        if (which == 0) data_bad_i = 1'b1;
        if (which == 1) rate_change_i = 1'b1;
        if (which == 2) begin data_bad_i = 1'b1; rate_change_i = 1'b1; end
        @(negedge clk);
        data_bad_i    = 1'b0;
        rate_change_i = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    // ---------------- driver ----------------
    initial begin : driver
        repeat (3) @(negedge clk);
        // R12 reset state
        chk({dly_rst_o, busy_o, aligned_o, failed_o} == 4'b0000, "R12 reset flags",
            {dly_rst_o, busy_o, aligned_o, failed_o}, 0);
        chk(retry_cnt_o == 0, "R12 reset retry", retry_cnt_o, 0);
        chk(sync_mode_o == 1'b1, "R11 sync mode", sync_mode_o, 1);
        rst_n = 1'b1;

        // R1: no lock, idle high: no request
        repeat (20) @(negedge clk);
        chk(busy_o == 1'b1, "R12 busy in WAIT_LOCK", busy_o, 1);
        chk(dly_rst_o == 1'b0, "R1 no lock", dly_rst_o, 0);
        cdr_lock_i = 1'b1;
        repeat (20) @(negedge clk);
        chk(dly_rst_o == 1'b0, "R1 still idle", dly_rst_o, 0);

        // R3 R4 first alignment
        expect_ev(EV_PULSE, 0, "R1 first request");
        expect_ev(EV_ALIGN, 0, "R4 first align");
        elec_idle_i = 1'b0;
        wait_aligned("R3 handshake order to aligned");
        chk(busy_o == 1'b0, "R12 not busy when aligned", busy_o, 0);

        // R11 sync-all loop
        sync_out_i = 1'b1;
        #1;
        chk(sync_all_o == 1'b1, "R11 sync all high", sync_all_o, 1);
        sync_out_i = 1'b0;
        #1;
        chk(sync_all_o == 1'b0, "R11 sync all low", sync_all_o, 0);

        // R6 bad data
        expect_ev(EV_PULSE, 1, "R6 bad data request");
        expect_ev(EV_ALIGN, 1, "R6 bad data align");
        @(negedge clk);
        data_bad_i = 1'b1;
        @(negedge clk);
        data_bad_i = 1'b0;
        chk(aligned_o == 1'b0, "R6 aligned drops", aligned_o, 0);
        chk(busy_o == 1'b1, "R6 restart busy", busy_o, 1);
        wait_aligned("R6 realign");

        // R8 rate change together with bad data
        expect_ev(EV_PULSE, 1, "R8 rate change request");
        expect_ev(EV_ALIGN, 1, "R8 rate change align");
        @(negedge clk);
        data_bad_i    = 1'b1;
        rate_change_i = 1'b1;
        @(negedge clk);
        data_bad_i    = 1'b0;
        rate_change_i = 1'b0;
        chk(aligned_o == 1'b0, "R8 aligned drops", aligned_o, 0);
        wait_aligned("R8 realign");
        chk(retry_cnt_o == 1, "R8 priority over bad data", retry_cnt_o, 1);

        // R9 loss of lock
        cdr_lock_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(aligned_o == 1'b0, "R9 lock loss drops aligned", aligned_o, 0);
        chk(busy_o == 1'b1, "R9 back to WAIT_LOCK", busy_o, 1);
        repeat (10) @(negedge clk);
        expect_ev(EV_PULSE, 1, "R9 relock request");
        expect_ev(EV_ALIGN, 1, "R9 relock align");
        cdr_lock_i = 1'b1;
        wait_aligned("R9 relock aligned");

        // R9 idle re-entry
        elec_idle_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(aligned_o == 1'b0, "R9 idle drops aligned", aligned_o, 0);
        expect_ev(EV_PULSE, 1, "R9 idle exit request");
        expect_ev(EV_ALIGN, 1, "R9 idle exit align");
        elec_idle_i = 1'b0;
        wait_aligned("R9 idle exit aligned");

        // R4 failed phase result
        phase_ok = 1'b0;
        expect_ev(EV_PULSE, 2, "R4 request before fail");
        expect_ev(EV_FAIL,  2, "R4 fail flag");
        expect_ev(EV_PULSE, 3, "R4 request after fail");
        expect_ev(EV_ALIGN, 3, "R4 align after fail");
        pulse_input(0);
        for (int i = 0; i < 2000 && !failed_o; i++) @(negedge clk);
        chk(failed_o == 1'b1, "R4 fail seen", failed_o, 1);
        phase_ok = 1'b1;
        @(negedge clk);
        chk(failed_o == 1'b0, "R4 fail one cycle", failed_o, 0);
        wait_aligned("R4 aligned after fail");

        // R5 sync timeout
        resp_sdone = 1'b0;
        expect_ev(EV_PULSE, 4, "R5 request no sync");
        expect_ev(EV_PULSE, 5, "R5 sync timeout");
        pulse_input(0);
        wait_drained("R5 sync timeout drained");

        // R5 delay-reset timeout and R10 saturation
        resp_sdone = 1'b1;
        resp_rdone = 1'b0;
        expect_ev(EV_PULSE, 6, "R5 rdone timeout 1");
        expect_ev(EV_PULSE, 7, "R5 rdone timeout 2");
        expect_ev(EV_PULSE, RETRY_MAX, "R10 saturated");
        wait_drained("R5 rdone timeouts drained");
        resp_rdone = 1'b1;
        expect_ev(EV_ALIGN, RETRY_MAX, "R10 align at max");
        wait_aligned("R5 recovery aligned");
        chk(retry_cnt_o == RETRY_MAX, "R10 count held", retry_cnt_o, RETRY_MAX);

        // R7 receiver reset
        @(negedge clk);
        rx_reset_i = 1'b1;
        @(negedge clk);
        chk({dly_rst_o, busy_o, aligned_o} == 3'b000, "R7 idle outputs",
            {dly_rst_o, busy_o, aligned_o}, 0);
        repeat (5) @(negedge clk);
        chk({dly_rst_o, busy_o, aligned_o} == 3'b000, "R7 held idle",
            {dly_rst_o, busy_o, aligned_o}, 0);
        chk(retry_cnt_o == RETRY_MAX, "R7 retry kept", retry_cnt_o, RETRY_MAX);
        expect_ev(EV_PULSE, RETRY_MAX, "R7 request after reset");
        expect_ev(EV_ALIGN, RETRY_MAX, "R7 align after reset");
        rx_reset_i = 1'b0;
        wait_aligned("R7 aligned after reset");

        wait_drained("scoreboard drained");
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule